// File: doc/BRIEF.md
# Nibble-Mode Reverse Byte Receiver

This block lets a host pull bytes back from a parallel-port peripheral once nibble mode is already agreed. Bytes arrive four bits at a time on the peripheral's status pins. The host asks for each nibble by lowering its auto-feed line. The peripheral answers by lowering its acknowledge line. The host takes the status pins and raises auto-feed as its own acknowledge. The peripheral then releases acknowledge. Two such rounds make one byte, low half first.

A transfer starts with a one-cycle `start` pulse and the number of bytes wanted. Each finished byte is offered on a valid/ready stream. The block does not ask for the next nibble until the consumer has taken the current byte. At the end, a one-cycle `doneStrobe` carries a completion code and the number of bytes delivered. This is reported for success and for errors alike. The select-in and strobe lines stay high the whole time. All five status inputs pass through synchronizers before they are used. Transfer lengths start at 1.

Top module: `nibrx_top`

## Requirements
- R1: After reset, `autoFdN`, `selectInN` and `strobeN` are high, `outValid` and `busy` are low, and `doneStrobe` is low.
- R2: A nibble is requested by driving `autoFdN` low. `autoFdN` is never low while `busy` is low.
- R3: Each byte is offered on `outData` with `outValid` high. It stays valid and unchanged until `outReady` is sampled high. Bytes arrive in the order the peripheral sent them.
- R4: Pin-to-bit mapping. The first nibble of a byte fills bits 3..0 and the second fills bits 7..4. Within a nibble, bit 0 is `faultN`, bit 1 is `select`, bit 2 is `paperErr` and bit 3 is `busyIn`.
- R5: While waiting for acknowledge low on the first nibble of a byte, the block waits up to `LONG_WAIT` clock cycles (default 2000). A peripheral answering after 1500 cycles is accepted.
- R6: If acknowledge does not fall within `LONG_WAIT` cycles on a first nibble, the transfer ends with code 1 (timeout). The end comes about `LONG_WAIT` cycles after the request.
- R7: If acknowledge does not fall within `SHORT_WAIT` cycles (default 6) on a second nibble, the transfer ends with code 1 (timeout). The byte is not delivered.
- R8: If acknowledge does not rise within `SHORT_WAIT` cycles after the second nibble's host acknowledge, the byte is still delivered. The transfer then ends with code 2 (I/O error).
- R9: `doneStrobe` is a single-cycle pulse. `doneCount` equals the number of bytes accepted on the stream. On success, `doneCode` is 0 and the count equals the requested length.
- R10: While `outValid` is high and `outReady` is low, `autoFdN` stays high, so no new request is made.
- R11: `selectInN` and `strobeN` are held high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| xferLen | input | LEN_W | Bytes to receive, captured with `start` |
| ackN | input | 1 | Peripheral acknowledge, asynchronous |
| faultN | input | 1 | Status pin, data bit 0/4 |
| select | input | 1 | Status pin, data bit 1/5 |
| paperErr | input | 1 | Status pin, data bit 2/6 |
| busyIn | input | 1 | Status pin, data bit 3/7 |
| autoFdN | output | 1 | Host request (low) / acknowledge (high) |
| selectInN | output | 1 | Held high |
| strobeN | output | 1 | Held high |
| outData | output | 8 | Assembled byte |
| outValid | output | 1 | Byte available |
| outReady | input | 1 | Consumer accepts byte |
| busy | output | 1 | Transfer in progress |
| doneStrobe | output | 1 | One-cycle end-of-transfer pulse |
| doneCode | output | 2 | 0 ok, 1 timeout, 2 I/O error |
| doneCount | output | LEN_W | Bytes delivered in this transfer |

## Verification
The status lines take `SYNC_STAGES` (2) edges to reach the control. An acknowledge edge driven just after a clock edge is acted on about three edges later. The bench therefore never checks handshake latency exactly. It follows the protocol by waiting on `autoFdN` and checks completion only when `doneStrobe` is seen at a falling clock edge. For the first-nibble timeout, the done pulse is due `LONG_WAIT` plus two or three cycles after `start`, and the bench checks a small window around that. Stream data and the stall rule are compared at every falling edge, between the edges at which the design updates.

// File: rtl/nibrx_pkg.sv
package nibrx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ_LO, ST_ACK_LO, ST_REQ_HI, ST_ACK_HI, ST_PUSH
  } rxState_t;

  typedef enum logic [1:0] {
    CODE_OK = 2'd0, CODE_TIMEOUT = 2'd1, CODE_IOERR = 2'd2
  } doneCode_t;

  typedef struct packed {
    logic loadLen;
    logic latchLo;
    logic latchHi;
    logic bump;
  } dpCtrl_t;
endpackage

// File: rtl/nibrx_sync.sv
module nibrx_sync #(
  parameter int WIDTH = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '1;
    else        chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '1;
      else        chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/nibrx_ctrl.sv
module nibrx_ctrl
  import nibrx_pkg::*;
#(
  parameter int LONG_WAIT  = 2000,
  parameter int SHORT_WAIT = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      ackSync,
  input  logic      outReady,
  input  logic      lastByte,
  output dpCtrl_t   dpCtrl,
  output logic      autoFdN,
  output logic      outValid,
  output logic      busy,
  output logic      doneStrobe,
  output doneCode_t doneCode
);
  localparam int WAIT_W = $clog2(LONG_WAIT + 1);
  localparam logic [WAIT_W-1:0] LONG_LAST  = WAIT_W'(LONG_WAIT - 1);
  localparam logic [WAIT_W-1:0] SHORT_LAST = WAIT_W'(SHORT_WAIT - 1);

  rxState_t          state;
  logic [WAIT_W-1:0] waitCnt;
  logic              errPend;
  logic              expired;

  assign expired = (state == ST_REQ_LO) ? (waitCnt == LONG_LAST)
                                        : (waitCnt == SHORT_LAST);

  assign dpCtrl.loadLen = (state == ST_IDLE) && start;
  assign dpCtrl.latchLo = (state == ST_REQ_LO) && !ackSync;
  assign dpCtrl.latchHi = (state == ST_REQ_HI) && !ackSync;
  assign dpCtrl.bump    = (state == ST_PUSH) && outReady;

  assign autoFdN  = !((state == ST_REQ_LO) || (state == ST_REQ_HI));
  assign outValid = (state == ST_PUSH);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      waitCnt    <= '0;
      errPend    <= 1'b0;
      doneStrobe <= 1'b0;
      doneCode   <= CODE_OK;
    end else begin
      doneStrobe <= 1'b0;
      waitCnt    <= waitCnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          waitCnt <= '0;
          if (start) state <= ST_REQ_LO;
        end
        ST_REQ_LO, ST_REQ_HI: begin
          if (!ackSync) begin
            state   <= (state == ST_REQ_LO) ? ST_ACK_LO : ST_ACK_HI;
            waitCnt <= '0;
          end else if (expired) begin
            state      <= ST_IDLE;
            doneStrobe <= 1'b1;
            doneCode   <= CODE_TIMEOUT;
          end
        end
        ST_ACK_LO: begin
          if (ackSync) begin
            state   <= ST_REQ_HI;
            waitCnt <= '0;
          end else if (expired) begin
            state      <= ST_IDLE;
            doneStrobe <= 1'b1;
            doneCode   <= CODE_TIMEOUT;
          end
        end
        ST_ACK_HI: begin
          if (ackSync || expired) begin
            state   <= ST_PUSH;
            errPend <= !ackSync;
          end
        end
        ST_PUSH: begin
          waitCnt <= '0;
          if (outReady) begin
            if (errPend || lastByte) begin
              state      <= ST_IDLE;
              doneStrobe <= 1'b1;
              doneCode   <= errPend ? CODE_IOERR : CODE_OK;
            end else begin
              state <= ST_REQ_LO;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nibrx_datapath.sv
module nibrx_datapath
  import nibrx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCtrl_t          dpCtrl,
  input  logic [LEN_W-1:0] xferLen,
  input  logic [3:0]       nibbleIn,
  output logic [7:0]       outData,
  output logic [LEN_W-1:0] byteCount,
  output logic             lastByte
);
  logic [LEN_W-1:0] lenReg;
  logic [3:0]       loNib;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lenReg    <= '0;
      loNib     <= '0;
      outData   <= '0;
      byteCount <= '0;
    end else begin
      if (dpCtrl.loadLen) begin
        lenReg    <= xferLen;
        byteCount <= '0;
      end else if (dpCtrl.bump) begin
        byteCount <= byteCount + 1'b1;
      end
      if (dpCtrl.latchLo) loNib   <= nibbleIn;
      if (dpCtrl.latchHi) outData <= {nibbleIn, loNib};
    end
  end

  assign lastByte = (byteCount + 1'b1) == lenReg;
endmodule

// File: rtl/nibrx_top.sv
module nibrx_top
  import nibrx_pkg::*;
#(
  parameter int LONG_WAIT   = 2000,
  parameter int SHORT_WAIT  = 6,
  parameter int LEN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] xferLen,
  input  logic             ackN,
  input  logic             faultN,
  input  logic             select,
  input  logic             paperErr,
  input  logic             busyIn,
  output logic             autoFdN,
  output logic             selectInN,
  output logic             strobeN,
  output logic [7:0]       outData,
  output logic             outValid,
  input  logic             outReady,
  output logic             busy,
  output logic             doneStrobe,
  output logic [1:0]       doneCode,
  output logic [LEN_W-1:0] doneCount
);
  logic [4:0] pinSync;
  dpCtrl_t    dpCtrl;
  logic       lastByte;
  doneCode_t  codeInt;

  nibrx_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .asyncIn({busyIn, paperErr, select, faultN, ackN}),
    .syncOut(pinSync)
  );

  nibrx_ctrl #(.LONG_WAIT(LONG_WAIT), .SHORT_WAIT(SHORT_WAIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ackSync(pinSync[0]),
    .outReady(outReady), .lastByte(lastByte), .dpCtrl(dpCtrl),
    .autoFdN(autoFdN), .outValid(outValid), .busy(busy),
    .doneStrobe(doneStrobe), .doneCode(codeInt)
  );

  nibrx_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .dpCtrl(dpCtrl), .xferLen(xferLen),
    .nibbleIn(pinSync[4:1]), .outData(outData), .byteCount(doneCount),
    .lastByte(lastByte)
  );

  assign doneCode  = codeInt;
  assign selectInN = 1'b1;
  assign strobeN   = 1'b1;
endmodule

// File: rtl/nibrx_checker.sv
module nibrx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       autoFdN,
  input logic       selectInN,
  input logic       strobeN,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outReady,
  input logic       busy,
  input logic       doneStrobe
);
  assert_idle_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> autoFdN);

  assert_hold_stream_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    doneStrobe |=> !doneStrobe);

  assert_stall_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> autoFdN);

  assert_fixed_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
    selectInN && strobeN);
endmodule

bind nibrx_top nibrx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .autoFdN(autoFdN), .selectInN(selectInN),
  .strobeN(strobeN), .outData(outData), .outValid(outValid),
  .outReady(outReady), .busy(busy), .doneStrobe(doneStrobe)
);

// File: tb/sim_nibrx_top.sv
`timescale 1ns/1ps
module sim_nibrx_top;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] xferLen = '0;
  logic ackN = 1'b1, faultN = 1'b1, select = 1'b1, paperErr = 1'b1, busyIn = 1'b1;
  logic outReady = 1'b1;
  logic autoFdN, selectInN, strobeN, outValid, busy, doneStrobe;
  logic [7:0] outData;
  logic [1:0] doneCode;
  logic [LEN_W-1:0] doneCount;

  always #2 clk = ~clk;

  nibrx_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .xferLen(xferLen), .ackN(ackN),
    .faultN(faultN), .select(select), .paperErr(paperErr), .busyIn(busyIn),
    .autoFdN(autoFdN), .selectInN(selectInN), .strobeN(strobeN),
    .outData(outData), .outValid(outValid), .outReady(outReady), .busy(busy),
    .doneStrobe(doneStrobe), .doneCode(doneCode), .doneCount(doneCount)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] expB [8];
  logic [7:0] rxQ [$];
  int monFixedBad = 0, monStallBad = 0, monHoldBad = 0;
  bit sawReq = 1'b0;
  logic prevStall = 1'b0;
  logic [7:0] prevData = '0;
  int gotCode, gotCount, gotCycles;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock reference comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!(selectInN && strobeN)) monFixedBad++;
      if (outValid && !outReady && !autoFdN) monStallBad++;
      if (prevStall && !(outValid && outData == prevData)) monHoldBad++;
      if (busy && !autoFdN) sawReq = 1'b1;
      if (outValid && outReady) rxQ.push_back(outData);
      prevStall = outValid && !outReady;
      prevData  = outData;
    end
  end

  // peripheral: hangKind 1 = never answer nibble hangNib, 2 = never release ack after it
  task automatic serve(input int nNib, input int hangNib, input int hangKind,
                       input int slowNib, input int slowDelay);
    for (int i = 0; i < nNib; i++) begin
      logic [3:0] nib;
      int d;
      wait (autoFdN == 1'b0);
      if (hangKind == 1 && i == hangNib) return;
      d = (i == slowNib) ? slowDelay : 1;
      repeat (d) @(posedge clk);
      #1;
      nib = i[0] ? expB[i/2][7:4] : expB[i/2][3:0];
      {busyIn, paperErr, select, faultN} = nib;
      ackN = 1'b0;
      wait (autoFdN == 1'b1);
      if (hangKind == 2 && i == hangNib) return;
      @(posedge clk);
      #1 ackN = 1'b1;
    end
  endtask

  task automatic kick(input int len);
    rxQ.delete();
    @(posedge clk); #1;
    xferLen = LEN_W'(len);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic waitDone();
    gotCycles = 0;
    @(negedge clk);
    while (!doneStrobe && gotCycles < 5000) begin
      @(negedge clk);
      gotCycles++;
    end
    gotCode  = int'(doneCode);
    gotCount = int'(doneCount);
  endtask

  task automatic checkBytes(input int n, input string req);
    check(rxQ.size() == n, req, rxQ.size(), n);
    for (int k = 0; k < n && k < rxQ.size(); k++)
      check(rxQ[k] == expB[k], req, int'(rxQ[k]), int'(expB[k]));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(autoFdN && selectInN && strobeN, "R1 lines", autoFdN, 1);
    check(!outValid && !busy && !doneStrobe, "R1 idle", {outValid, busy, doneStrobe}, 0);

    // R3/R4/R9 basic transfer, several patterns
    expB[0] = 8'hA5; expB[1] = 8'h3C; expB[2] = 8'h00; expB[3] = 8'hFF;
    kick(4);
    fork serve(8, -1, 0, -1, 0); waitDone(); join
    check(gotCode == 0, "R9 code ok", gotCode, 0);
    check(gotCount == 4, "R9 count", gotCount, 4);
    checkBytes(4, "R3 R4 bytes");
    check(sawReq, "R2 request seen", sawReq, 1);
    check(!busy && autoFdN, "R2 idle after", autoFdN, 1);

    // R4 single-bit mapping: bit0 from faultN, bit7 from busyIn
    expB[0] = 8'h01; expB[1] = 8'h80; expB[2] = 8'h24;
    kick(3);
    fork serve(6, -1, 0, -1, 0); waitDone(); join
    checkBytes(3, "R4 mapping");

    // R5 slow first nibble still accepted
    expB[0] = 8'h96;
    kick(1);
    fork serve(2, -1, 0, 0, 1500); waitDone(); join
    check(gotCode == 0, "R5 slow first ok", gotCode, 0);
    checkBytes(1, "R5 byte");

    // R6 first nibble never answered
    kick(2);
    fork serve(2, 0, 1, -1, 0); waitDone(); join
    check(gotCode == 1, "R6 code", gotCode, 1);
    check(gotCount == 0, "R6 count", gotCount, 0);
    check(gotCycles >= 1995 && gotCycles <= 2010, "R6 latency", gotCycles, 2001);

    // R7 second nibble of second byte never answered
    expB[0] = 8'h7E; expB[1] = 8'h11;
    kick(3);
    fork serve(4, 3, 1, -1, 0); waitDone(); join
    check(gotCode == 1, "R7 code", gotCode, 1);
    check(gotCount == 1, "R7 count", gotCount, 1);
    checkBytes(1, "R7 bytes");

    // R8 final ack-high never seen
    expB[0] = 8'hB2;
    kick(2);
    fork serve(2, 1, 2, -1, 0); waitDone(); join
    check(gotCode == 2, "R8 code", gotCode, 2);
    check(gotCount == 1, "R8 count", gotCount, 1);
    checkBytes(1, "R8 byte delivered");
    @(posedge clk); #1 ackN = 1'b1;
    repeat (4) @(posedge clk);

    // R10 backpressure
    expB[0] = 8'h5A; expB[1] = 8'hC3;
    #1 outReady = 1'b0;
    kick(2);
    fork
      serve(4, -1, 0, -1, 0);
      begin
        wait (outValid == 1'b1);
        repeat (40) begin
          @(negedge clk);
          check(autoFdN && outValid && outData == 8'h5A, "R10 stall", autoFdN, 1);
        end
        @(posedge clk); #1 outReady = 1'b1;
      end
      waitDone();
    join
    check(gotCode == 0 && gotCount == 2, "R10 result", gotCount, 2);
    checkBytes(2, "R10 bytes");

    check(monFixedBad == 0, "R11 fixed lines", monFixedBad, 0);
    check(monStallBad == 0, "R10 monitor", monStallBad, 0);
    check(monHoldBad == 0, "R3 hold monitor", monHoldBad, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule